// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block takes two IEEE-754 floating-point operands, binary64 by default or binary128 when `DATA_W` is 128, and turns them into a 4-bit one-hot condition code. The code says whether A is less than, greater than or equal to B, or whether the pair is unordered because at least one operand is a NaN. The same step produces the two invalid-operation flag pulses that a compare must report. One raises when a signaling NaN is seen. The other is the invalid-compare flag, which follows the ordered/unordered mode, the NaN kind and the invalid-operation enable bit.

Operands enter over a valid/ready handshake, and the result leaves over another one. A compare is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is registered and shows on `out_valid` in the following cycle. The result stays held, unchanged, until a cycle in which `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops new input.

Each accepted compare also reloads a held copy of the condition code, `fpcc_o`, that stands in for the status register's compare field. The consumer writes `out_cc` into its condition-register field.

Top module: `fpcmp_unit`

## Requirements
- R1: If either operand is a NaN (all-ones exponent, nonzero fraction), `out_cc` is 4'b0001: only the unordered bit is set, and less, greater and equal are clear.
- R2: For two non-NaN operands, exactly one of less (bit 3), greater (bit 2) or equal (bit 1) is set in `out_cc`, according to A < B, A > B or A == B, with negative values ordered below positive ones.
- R3: +0 and -0 compare equal. Infinities of the same sign compare equal. +inf is greater than any finite value, and -inf is less than any finite value.
- R4: `out_vx_snan` is high with the result whenever either operand is a signaling NaN (a NaN whose top fraction bit is 0), in both ordered and unordered mode. It is low otherwise.
- R5: In ordered mode (`in_ordered`=1) with a signaling-NaN operand, `out_vx_cmp` is high exactly when `in_ve` is 0.
- R6: In ordered mode with a quiet-NaN operand and no signaling NaN present, `out_vx_cmp` is high regardless of `in_ve`.
- R7: In unordered mode (`in_ordered`=0), `out_vx_cmp` stays low for every operand pair.
- R8: `fpcc_o` resets to 0. It is reloaded with the new condition code on every accepted compare and keeps its value otherwise.
- R9: A result appears on `out_valid` in the cycle after acceptance. With `out_ready` high it is valid for one cycle. Both flag outputs are low while `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_cc` and the flags hold their values.
- R11: With `DATA_W`=128 (15-bit exponent) the same condition-code and flag rules hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_a | input | DATA_W | Operand A |
| in_b | input | DATA_W | Operand B |
| in_ordered | input | 1 | 1 = ordered compare, 0 = unordered compare |
| in_ve | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_cc | output | 4 | Condition code {LT, GT, EQ, UN} |
| out_vx_snan | output | 1 | Signaling-NaN invalid flag, valid with the result |
| out_vx_cmp | output | 1 | Invalid-compare flag, valid with the result |
| fpcc_o | output | 4 | Held compare field, reloaded on every accepted compare |

## Verification
The bench builds two instances side by side: one with `DATA_W`=64 and one with `DATA_W`=128. The 64-bit instance covers ordering of signed finite values, signed zeros and infinities, both NaN kinds in both modes under both enable values, the held compare field, and a stalled consumer. The 128-bit instance runs the same rules with a 15-bit exponent and a 112-bit fraction. This shows that NaN detection, the quiet bit position and the magnitude compare all follow the parameter and are not fixed to the 64-bit layout.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Condition-code bit positions: {LT, GT, EQ, UN}
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;
  localparam int CC_W  = 4;

  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } opnd_cls_t;

  // Exponent field width for a supported interchange width
  function automatic int exp_width(input int w);
    if (w == 128) return 15;
    else if (w == 32) return 8;
    else return 11;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]     op,
  output fpcmp_pkg::opnd_cls_t  cls
);
  localparam int EXP_W  = fpcmp_pkg::exp_width(DATA_W);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  always_comb begin
    exp_f    = op[DATA_W-2 -: EXP_W];
    frac_f   = op[FRAC_W-1:0];
    exp_ones = &exp_f;
    frac_nz  = |frac_f;
    cls.sign = op[DATA_W-1];
    cls.zero = ~|op[DATA_W-2:0];
    cls.nan  = exp_ones & frac_nz;
    // quiet bit is the top fraction bit; clear means signaling
    cls.snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  input  fpcmp_pkg::opnd_cls_t       cls_a,
  input  fpcmp_pkg::opnd_cls_t       cls_b,
  output logic [fpcmp_pkg::CC_W-1:0] cc
);
  import fpcmp_pkg::*;

  localparam int MAG_W = DATA_W - 1;

  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             mag_eq;
  logic             mag_lt;
  logic             a_less;

  always_comb begin
    mag_a  = a[MAG_W-1:0];
    mag_b  = b[MAG_W-1:0];
    mag_eq = (mag_a == mag_b);
    mag_lt = (mag_a < mag_b);
    a_less = 1'b0;
    cc     = '0;
    if (cls_a.nan || cls_b.nan) begin
      cc[CC_UN] = 1'b1;
    end else if (cls_a.zero && cls_b.zero) begin
      cc[CC_EQ] = 1'b1;
    end else if (cls_a.sign != cls_b.sign) begin
      if (cls_a.sign) cc[CC_LT] = 1'b1;
      else            cc[CC_GT] = 1'b1;
    end else if (mag_eq) begin
      cc[CC_EQ] = 1'b1;
    end else begin
      // sign-magnitude: larger magnitude is smaller when negative
      a_less = mag_lt ^ cls_a.sign;
      if (a_less) cc[CC_LT] = 1'b1;
      else        cc[CC_GT] = 1'b1;
    end
  end

endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags (
  input  fpcmp_pkg::opnd_cls_t cls_a,
  input  fpcmp_pkg::opnd_cls_t cls_b,
  input  logic                 ordered,
  input  logic                 ve,
  output logic                 vx_snan,
  output logic                 vx_cmp
);
  logic any_snan;
  logic any_nan;

  always_comb begin
    any_snan = cls_a.snan | cls_b.snan;
    any_nan  = cls_a.nan | cls_b.nan;
    vx_snan  = any_snan;
    if (!ordered)      vx_cmp = 1'b0;
    else if (any_snan) vx_cmp = ~ve;
    else               vx_cmp = any_nan;
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_ordered,
  input  logic              in_ve,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_cc,
  output logic              out_vx_snan,
  output logic              out_vx_cmp,
  output logic [3:0]        fpcc_o
);
  import fpcmp_pkg::*;

  localparam int N_OPS = 2;

  logic [DATA_W-1:0] ops [N_OPS];
  opnd_cls_t         cls [N_OPS];

  logic [CC_W-1:0] cc_n;
  logic            snan_n;
  logic            vxc_n;
  logic            accept;

  logic            vld_q;
  logic [CC_W-1:0] cc_q;
  logic            snan_q;
  logic            vxc_q;
  logic [CC_W-1:0] fpcc_q;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpcmp_classify #(.DATA_W(DATA_W)) cls_i (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  fpcmp_order #(.DATA_W(DATA_W)) ord_i (
    .a     (in_a),
    .b     (in_b),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .cc    (cc_n)
  );

  fpcmp_flags flg_i (
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .ordered (in_ordered),
    .ve      (in_ve),
    .vx_snan (snan_n),
    .vx_cmp  (vxc_n)
  );

  assign in_ready = ~vld_q | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cc_q   <= '0;
      snan_q <= 1'b0;
      vxc_q  <= 1'b0;
      fpcc_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      cc_q   <= cc_n;
      snan_q <= snan_n;
      vxc_q  <= vxc_n;
      fpcc_q <= cc_n;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid   = vld_q;
  assign out_cc      = cc_q;
  assign out_vx_snan = snan_q & vld_q;
  assign out_vx_cmp  = vxc_q & vld_q;
  assign fpcc_o      = fpcc_q;

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              in_ordered,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_cc,
  input logic              out_vx_snan,
  input logic              out_vx_cmp,
  input logic [3:0]        fpcc_o
);
  localparam int EXP_W  = fpcmp_pkg::exp_width(DATA_W);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;

  logic acc;
  logic a_nan, b_nan, a_sn, b_sn;

  assign acc   = in_valid & in_ready;
  assign a_nan = (&in_a[DATA_W-2 -: EXP_W]) & (|in_a[FRAC_W-1:0]);
  assign b_nan = (&in_b[DATA_W-2 -: EXP_W]) & (|in_b[FRAC_W-1:0]);
  assign a_sn  = a_nan & ~in_a[FRAC_W-1];
  assign b_sn  = b_nan & ~in_b[FRAC_W-1];

  a_r1_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (a_nan || b_nan) |=> out_cc == 4'b0001);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_cc) == 1);

  a_r4_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (a_sn || b_sn) |=> out_vx_snan);

  a_r7_unord_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_ordered |=> !out_vx_cmp);

  a_r8_fpcc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(fpcc_o));

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r9_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_vx_snan && !out_vx_cmp);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cc)
      && $stable(out_vx_snan) && $stable(out_vx_cmp));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

bind fpcmp_unit fpcmp_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .in_ordered  (in_ordered),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_cc      (out_cc),
  .out_vx_snan (out_vx_snan),
  .out_vx_cmp  (out_vx_cmp),
  .fpcc_o      (fpcc_o)
);

// File: tb/fpcmp_unit_tb_top.sv
`timescale 1ns/1ps
module fpcmp_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // binary64 constants
  localparam logic [63:0] D_P1   = 64'h3FF0000000000000;
  localparam logic [63:0] D_P2   = 64'h4000000000000000;
  localparam logic [63:0] D_M1   = 64'hBFF0000000000000;
  localparam logic [63:0] D_M2   = 64'hC000000000000000;
  localparam logic [63:0] D_PZ   = 64'h0000000000000000;
  localparam logic [63:0] D_MZ   = 64'h8000000000000000;
  localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
  localparam logic [63:0] D_MINF = 64'hFFF0000000000000;
  localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
  // binary128 constants
  localparam logic [127:0] Q_P1   = {16'h3FFF, 112'h0};
  localparam logic [127:0] Q_P2   = {16'h4000, 112'h0};
  localparam logic [127:0] Q_M1   = {16'hBFFF, 112'h0};
  localparam logic [127:0] Q_PINF = {16'h7FFF, 112'h0};
  localparam logic [127:0] Q_QNAN = {16'h7FFF, 1'b1, 111'h0};
  localparam logic [127:0] Q_SNAN = {16'h7FFF, 111'h0, 1'b1};
  // 64-bit quiet pattern placed in a 128-bit word: finite there
  localparam logic [127:0] Q_LOOKS64 = {64'h7FF8000000000000, 64'h0};

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  logic        ordy = 1'b1;
  logic        ord = 1'b1;
  logic        ve = 1'b0;

  logic        v64 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        r64, ov64, sn64, vc64;
  logic [3:0]  cc64, fp64;

  logic         v128 = 1'b0;
  logic [127:0] a128 = '0, b128 = '0;
  logic         r128, ov128, sn128, vc128;
  logic [3:0]   cc128, fp128;

  fpcmp_unit #(.DATA_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v64), .in_ready(r64),
    .in_a(a64), .in_b(b64), .in_ordered(ord), .in_ve(ve),
    .out_valid(ov64), .out_ready(ordy), .out_cc(cc64),
    .out_vx_snan(sn64), .out_vx_cmp(vc64), .fpcc_o(fp64));

  fpcmp_unit #(.DATA_W(128)) dut_q (
    .clk(clk), .rst_n(rst_n), .in_valid(v128), .in_ready(r128),
    .in_a(a128), .in_b(b128), .in_ordered(ord), .in_ve(ve),
    .out_valid(ov128), .out_ready(ordy), .out_cc(cc128),
    .out_vx_snan(sn128), .out_vx_cmp(vc128), .fpcc_o(fp128));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // One compare on the chosen instance; checks result cycle and fpcc
  task automatic cmp(input bit wide, input string req,
                     input logic [127:0] a, input logic [127:0] b,
                     input logic o, input logic e,
                     input logic [3:0] exp_cc, input logic exp_sn,
                     input logic exp_vc);
    @(negedge clk);
    ord = o; ve = e;
    if (wide) begin a128 = a; b128 = b; v128 = 1'b1; end
    else      begin a64 = a[63:0]; b64 = b[63:0]; v64 = 1'b1; end
    @(negedge clk);
    v64 = 1'b0; v128 = 1'b0;
    if (wide) begin
      chk("R9",  "out_valid", {3'b0, ov128}, 4'b0001);
      chk(req,   "cc",        cc128, exp_cc);
      chk(req,   "vx_snan",   {3'b0, sn128}, {3'b0, exp_sn});
      chk(req,   "vx_cmp",    {3'b0, vc128}, {3'b0, exp_vc});
      chk("R8",  "fpcc",      fp128, exp_cc);
    end else begin
      chk("R9",  "out_valid", {3'b0, ov64}, 4'b0001);
      chk(req,   "cc",        cc64, exp_cc);
      chk(req,   "vx_snan",   {3'b0, sn64}, {3'b0, exp_sn});
      chk(req,   "vx_cmp",    {3'b0, vc64}, {3'b0, exp_vc});
      chk("R8",  "fpcc",      fp64, exp_cc);
    end
  endtask

  task automatic t_reset();
    chk("R9", "reset out_valid", {3'b0, ov64}, 4'b0000);
    chk("R8", "reset fpcc",      fp64, 4'b0000);
    chk("R10", "reset in_ready", {3'b0, r64}, 4'b0001);
    chk("R8", "reset fpcc wide", fp128, 4'b0000);
  endtask

  task automatic t_order();
    cmp(0, "R2", {64'h0, D_P1}, {64'h0, D_P2}, 1, 0, CC_LT, 0, 0);
    cmp(0, "R2", {64'h0, D_P2}, {64'h0, D_P1}, 1, 0, CC_GT, 0, 0);
    cmp(0, "R2", {64'h0, D_P1}, {64'h0, D_P1}, 0, 0, CC_EQ, 0, 0);
    cmp(0, "R2", {64'h0, D_M2}, {64'h0, D_M1}, 1, 0, CC_LT, 0, 0);
    cmp(0, "R2", {64'h0, D_M1}, {64'h0, D_P1}, 1, 0, CC_LT, 0, 0);
    cmp(0, "R2", {64'h0, D_P1}, {64'h0, D_M2}, 0, 1, CC_GT, 0, 0);
  endtask

  task automatic t_special();
    cmp(0, "R3", {64'h0, D_PZ},   {64'h0, D_MZ},   1, 0, CC_EQ, 0, 0);
    cmp(0, "R3", {64'h0, D_MZ},   {64'h0, D_PZ},   1, 0, CC_EQ, 0, 0);
    cmp(0, "R3", {64'h0, D_PINF}, {64'h0, D_PINF}, 1, 0, CC_EQ, 0, 0);
    cmp(0, "R3", {64'h0, D_MINF}, {64'h0, D_MINF}, 1, 0, CC_EQ, 0, 0);
    cmp(0, "R3", {64'h0, D_PINF}, {64'h0, D_P2},   1, 0, CC_GT, 0, 0);
    cmp(0, "R3", {64'h0, D_MINF}, {64'h0, D_M2},   1, 0, CC_LT, 0, 0);
    cmp(0, "R3", {64'h0, D_MINF}, {64'h0, D_PINF}, 1, 0, CC_LT, 0, 0);
  endtask

  task automatic t_nan();
    cmp(0, "R1", {64'h0, D_QNAN}, {64'h0, D_P1},   0, 0, CC_UN, 0, 0);
    cmp(0, "R1", {64'h0, D_P1},   {64'h0, D_QNAN}, 0, 1, CC_UN, 0, 0);
    cmp(0, "R1", {64'h0, D_QNAN}, {64'h0, D_QNAN}, 0, 0, CC_UN, 0, 0);
    cmp(0, "R4", {64'h0, D_SNAN}, {64'h0, D_P1},   0, 0, CC_UN, 1, 0);
    cmp(0, "R4", {64'h0, D_P1},   {64'h0, D_SNAN}, 1, 1, CC_UN, 1, 0);
  endtask

  task automatic t_flags();
    cmp(0, "R5", {64'h0, D_SNAN}, {64'h0, D_P2},   1, 0, CC_UN, 1, 1);
    cmp(0, "R5", {64'h0, D_SNAN}, {64'h0, D_P2},   1, 1, CC_UN, 1, 0);
    cmp(0, "R5", {64'h0, D_SNAN}, {64'h0, D_QNAN}, 1, 1, CC_UN, 1, 0);
    cmp(0, "R6", {64'h0, D_QNAN}, {64'h0, D_P2},   1, 0, CC_UN, 0, 1);
    cmp(0, "R6", {64'h0, D_P2},   {64'h0, D_QNAN}, 1, 1, CC_UN, 0, 1);
    cmp(0, "R7", {64'h0, D_QNAN}, {64'h0, D_SNAN}, 0, 0, CC_UN, 1, 0);
    cmp(0, "R7", {64'h0, D_QNAN}, {64'h0, D_P1},   0, 1, CC_UN, 0, 0);
  endtask

  task automatic t_idle();
    // one cycle after the result with out_ready high: empty, flags low
    cmp(0, "R5", {64'h0, D_SNAN}, {64'h0, D_P2}, 1, 0, CC_UN, 1, 1);
    @(negedge clk);
    chk("R9", "valid drops", {3'b0, ov64}, 4'b0000);
    chk("R9", "snan flag idle", {3'b0, sn64}, 4'b0000);
    chk("R9", "cmp flag idle",  {3'b0, vc64}, 4'b0000);
    chk("R8", "fpcc held", fp64, CC_UN);
    repeat (3) @(negedge clk);
    chk("R8", "fpcc still held", fp64, CC_UN);
  endtask

  task automatic t_stall();
    @(negedge clk);
    ordy = 1'b0; ord = 1'b1; ve = 1'b0;
    a64 = D_P1; b64 = D_P2; v64 = 1'b1;
    @(negedge clk);
    // second pair waits while the first result is held
    a64 = D_P2; b64 = D_P1;
    chk("R10", "in_ready low", {3'b0, r64}, 4'b0000);
    chk("R10", "held valid", {3'b0, ov64}, 4'b0001);
    chk("R10", "held cc", cc64, CC_LT);
    repeat (2) @(negedge clk);
    chk("R10", "still held cc", cc64, CC_LT);
    chk("R10", "still valid", {3'b0, ov64}, 4'b0001);
    chk("R8", "fpcc during stall", fp64, CC_LT);
    ordy = 1'b1;
    @(negedge clk);
    v64 = 1'b0;
    chk("R10", "next result", cc64, CC_GT);
    chk("R10", "next valid", {3'b0, ov64}, 4'b0001);
    @(negedge clk);
    chk("R9", "drained", {3'b0, ov64}, 4'b0000);
  endtask

  task automatic t_wide();
    cmp(1, "R11", Q_P1,   Q_P2,   1, 0, CC_LT, 0, 0);
    cmp(1, "R11", Q_M1,   Q_P1,   1, 0, CC_LT, 0, 0);
    cmp(1, "R11", Q_PINF, Q_P2,   1, 0, CC_GT, 0, 0);
    cmp(1, "R11", Q_P2,   Q_P2,   0, 0, CC_EQ, 0, 0);
    cmp(1, "R11", Q_QNAN, Q_P1,   1, 0, CC_UN, 0, 1);
    cmp(1, "R11", Q_SNAN, Q_P1,   1, 1, CC_UN, 1, 0);
    cmp(1, "R11", Q_SNAN, Q_P1,   0, 0, CC_UN, 1, 0);
    cmp(1, "R11", Q_LOOKS64, Q_P1, 1, 0, CC_GT, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_order();
    t_special();
    t_nan();
    t_flags();
    t_idle();
    t_stall();
    t_wide();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule